// File: doc/BRIEF.md
# Refresh and Self-Refresh Scheduler

This block keeps an SDRAM refreshed on behalf of a memory controller. A free-running interval counter, sized from a clock-period parameter, adds one owed refresh every 7.8 µs. The command arbiter sees a refresh request whenever at least one refresh is owed and all banks are idle. It answers with an acknowledge for each auto-refresh command it issues. Refreshes may be postponed up to a bounded count. When that bound is reached, new reads are withheld so that the arbiter drains the backlog.

The block also drives the clock-enable level. A self-refresh request with all banks idle lowers clock enable and clears the backlog, because the device refreshes itself and its DLL is off. Dropping the request raises clock enable again. After that exit, non-read commands stay blocked for a short recovery window, and reads stay blocked for the much longer DLL relock window. A power-down request lowers clock enable while nothing is owed. Power-down ends when the request drops, or on its own when a refresh falls due.

Top module: `rfsh_scheduler`

## Requirements
- R1: During and straight after reset, cke, grantRead and grantOther are 1, while refReq and selfRefresh are 0.
- R2: Outside self-refresh, one refresh becomes owed every REFI_CYC = (REFI_NS*1000)/CLK_PERIOD_PS clock cycles, counted from reset release or from self-refresh exit. The first one is owed after exactly REFI_CYC rising edges. refReq is 1 exactly when the block is in normal operation, at least one refresh is owed and banksIdle is 1.
- R3: A cycle with refReq and refAck both 1 retires one owed refresh. refAck while refReq is 0 has no effect.
- R4: The owed count saturates at MAX_POSTPONE, and a further interval expiry at the bound is dropped. While the count is at the bound, grantRead is 0.
- R5: In normal operation, srReq together with banksIdle enters self-refresh at the next edge: cke goes to 0 and selfRefresh to 1, and the owed count is cleared. srReq without banksIdle does not enter.
- R6: In self-refresh, refReq stays 0, no refresh is owed, and the block stays there while srReq is 1.
- R7: When srReq drops in self-refresh, cke returns to 1 at the next edge, and grantOther stays 0 for the first XSNR_CYC (10) cycles after that edge.
- R8: After self-refresh exit, grantRead stays 0 for the first XSRD_CYC (200) cycles. grantRead is never 1 while grantOther is 0.
- R9: In normal operation, pdReq with srReq 0 and nothing owed enters power-down at the next edge: cke, grantRead, grantOther and refReq are 0. Power-down ends at the edge after pdReq drops, srReq rises or a refresh becomes owed. It is not re-entered while a refresh is owed.
- R10: When srReq and pdReq are both 1 with banksIdle, self-refresh is entered rather than power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| banksIdle | input | 1 | All banks are precharged |
| refAck | input | 1 | Arbiter issues the auto-refresh now |
| srReq | input | 1 | Level request to stay in self-refresh |
| pdReq | input | 1 | Level request for power-down |
| refReq | output | 1 | An auto-refresh is owed and may be issued |
| grantRead | output | 1 | New read commands allowed |
| grantOther | output | 1 | Non-read commands allowed |
| cke | output | 1 | Clock-enable level for the pad |
| selfRefresh | output | 1 | Device is in self-refresh |

## Verification
The bench measures the exact hold-off windows after self-refresh exit. A design that shared one counter between the two windows would release reads after 10 cycles, and an off-by-one load would shift either edge by a cycle. It fills the postponement backlog to its bound and lets one more interval expire. It then counts the acknowledges needed to drain the backlog, so a counter that wrapped or kept the dropped tick shows a count other than MAX_POSTPONE. It also checks the following cases:
- acknowledges arriving with no request pending, which a careless decrement would count;
- self-refresh requested while banks are busy;
- power-down that must end by itself when a refresh falls due;
- simultaneous self-refresh and power-down requests.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SELF = 2'd1,
    ST_PDN  = 2'd2
  } rfsh_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tickEn;
    logic tickClr;
    logic owedClr;
    logic refDone;
    logic holdLoad;
  } rfsh_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic owedZero;
    logic owedFull;
    logic otherReady;
    logic readReady;
  } rfsh_status_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int REFI_CYC     = 390,
  parameter int MAX_POSTPONE = 8,
  parameter int XSNR_CYC     = 10,
  parameter int XSRD_CYC     = 200
) (
  input  logic         clk,
  input  logic         rstN,
  input  rfsh_strobe_t strb,
  output rfsh_status_t stat
);

  localparam int TW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam int OW = $clog2(MAX_POSTPONE + 1);
  localparam int HW = $clog2(XSRD_CYC + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(REFI_CYC - 1);
  localparam logic [OW-1:0] OWED_MAX  = OW'(MAX_POSTPONE);

  logic [TW-1:0] tickCnt;
  logic          tick;
  logic [OW-1:0] owedCnt;
  logic [1:0]    holdDone;

  // interval counter: wraps every REFI_CYC enabled cycles
  assign tick = strb.tickEn && (tickCnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.tickClr) begin
      tickCnt <= '0;
    end else if (strb.tickEn) begin
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
    end
  end

  // owed refresh backlog, saturating at the postponement bound
  always_ff @(posedge clk) begin
    if (!rstN) begin
      owedCnt <= '0;
    end else if (strb.owedClr) begin
      owedCnt <= '0;
    end else if (tick && !strb.refDone) begin
      if (owedCnt != OWED_MAX) owedCnt <= owedCnt + 1'b1;
    end else if (!tick && strb.refDone) begin
      owedCnt <= owedCnt - 1'b1;
    end
  end

  // two hold-off counters after self-refresh exit: 0 = non-read, 1 = read
  for (genvar g = 0; g < 2; g++) begin : gHold
    localparam logic [HW-1:0] LIMIT = HW'((g == 0) ? XSNR_CYC : XSRD_CYC);
    logic [HW-1:0] holdCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdCnt <= '0;
      end else if (strb.holdLoad) begin
        holdCnt <= LIMIT;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end

    assign holdDone[g] = (holdCnt == '0);
  end

  assign stat.owedZero   = (owedCnt == '0);
  assign stat.owedFull   = (owedCnt == OWED_MAX);
  assign stat.otherReady = holdDone[0];
  assign stat.readReady  = holdDone[1];

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         banksIdle,
  input  logic         refAck,
  input  logic         srReq,
  input  logic         pdReq,
  input  rfsh_status_t stat,
  output rfsh_strobe_t strb,
  output logic         refReq,
  output logic         grantRead,
  output logic         grantOther,
  output logic         cke,
  output logic         selfRefresh
);

  rfsh_state_e state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    unique case (state)
      ST_RUN: begin
        if (srReq && banksIdle)                   nxtState = ST_SELF;
        else if (pdReq && !srReq && stat.owedZero) nxtState = ST_PDN;
      end
      ST_SELF: begin
        if (!srReq) nxtState = ST_RUN;
      end
      ST_PDN: begin
        if (!pdReq || srReq || !stat.owedZero) nxtState = ST_RUN;
      end
      default: nxtState = ST_RUN;
    endcase
  end

  assign refReq      = (state == ST_RUN) && !stat.owedZero && banksIdle;
  assign grantOther  = (state == ST_RUN) && stat.otherReady;
  assign grantRead   = (state == ST_RUN) && stat.readReady && !stat.owedFull;
  assign cke         = (state == ST_RUN);
  assign selfRefresh = (state == ST_SELF);

  always_comb begin
    strb          = '0;
    strb.tickEn   = (state != ST_SELF);
    strb.holdLoad = (state == ST_SELF) && !srReq;
    strb.tickClr  = (state == ST_SELF) && !srReq;
    strb.owedClr  = (state == ST_RUN) && (nxtState == ST_SELF);
    strb.refDone  = refReq && refAck;
  end

endmodule

// File: rtl/rfsh_scheduler.sv
module rfsh_scheduler
  import rfsh_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int REFI_NS       = 7800,
  parameter int MAX_POSTPONE  = 8,
  parameter int XSNR_CYC      = 10,
  parameter int XSRD_CYC      = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic banksIdle,
  input  logic refAck,
  input  logic srReq,
  input  logic pdReq,
  output logic refReq,
  output logic grantRead,
  output logic grantOther,
  output logic cke,
  output logic selfRefresh
);

  localparam int REFI_CYC = (REFI_NS * 1000) / CLK_PERIOD_PS;

  rfsh_strobe_t strb;
  rfsh_status_t stat;

  rfsh_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .banksIdle  (banksIdle),
    .refAck     (refAck),
    .srReq      (srReq),
    .pdReq      (pdReq),
    .stat       (stat),
    .strb       (strb),
    .refReq     (refReq),
    .grantRead  (grantRead),
    .grantOther (grantOther),
    .cke        (cke),
    .selfRefresh(selfRefresh)
  );

  rfsh_datapath #(
    .REFI_CYC    (REFI_CYC),
    .MAX_POSTPONE(MAX_POSTPONE),
    .XSNR_CYC    (XSNR_CYC),
    .XSRD_CYC    (XSRD_CYC)
  ) i_dp (
    .clk (clk),
    .rstN(rstN),
    .strb(strb),
    .stat(stat)
  );

endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
  parameter int XSNR_CYC = 10,
  parameter int XSRD_CYC = 200
) (
  input logic clk,
  input logic rstN,
  input logic banksIdle,
  input logic srReq,
  input logic refReq,
  input logic grantRead,
  input logic grantOther,
  input logic cke,
  input logic selfRefresh
);

  // cycles since the last self-refresh exit edge, saturating
  logic [15:0] sinceExit;

  always_ff @(posedge clk) begin
    if (!rstN)                             sinceExit <= 16'(XSRD_CYC);
    else if (selfRefresh)                  sinceExit <= '0;
    else if (sinceExit < 16'(XSRD_CYC))    sinceExit <= sinceExit + 1'b1;
  end

  a_r2_req_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> banksIdle);

  a_r5_entry_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfRefresh) |-> $past(banksIdle) && $past(srReq));

  a_r6_no_ref_in_sr: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |-> !refReq && !cke);

  a_r6_sr_held: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh && srReq |=> selfRefresh);

  a_r7_other_holdoff: assert property (@(posedge clk) disable iff (!rstN)
    (sinceExit < 16'(XSNR_CYC)) |-> !grantOther);

  a_r8_read_holdoff: assert property (@(posedge clk) disable iff (!rstN)
    (sinceExit < 16'(XSRD_CYC)) |-> !grantRead);

  a_r8_read_implies_other: assert property (@(posedge clk) disable iff (!rstN)
    grantRead |-> grantOther);

  a_r9_cke_low_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> !grantRead && !grantOther && !refReq);

endmodule

bind rfsh_scheduler rfsh_checker #(
  .XSNR_CYC(XSNR_CYC),
  .XSRD_CYC(XSRD_CYC)
) i_rfsh_checker (
  .clk        (clk),
  .rstN       (rstN),
  .banksIdle  (banksIdle),
  .srReq      (srReq),
  .refReq     (refReq),
  .grantRead  (grantRead),
  .grantOther (grantOther),
  .cke        (cke),
  .selfRefresh(selfRefresh)
);

// File: tb/test_rfsh_scheduler.sv
`timescale 1ns/1ps
module test_rfsh_scheduler;

  localparam int CLK_PS   = 20000;
  localparam int REFI     = (7800 * 1000) / CLK_PS;
  localparam int MAXP     = 8;
  localparam int XSNR     = 10;
  localparam int XSRD     = 200;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic banksIdle = 1'b1, refAck = 1'b0, srReq = 1'b0, pdReq = 1'b0;
  logic refReq, grantRead, grantOther, cke, selfRefresh;

  int nChecks = 0;
  int nFails  = 0;
  bit modelOn = 0;
  bit done    = 0;

  // reference model: 0 = normal, 1 = self-refresh, 2 = power-down
  int mState = 0, mTick = 0, mOwed = 0, mHoldO = 0, mHoldR = 0;

  rfsh_scheduler #(.CLK_PERIOD_PS(CLK_PS), .REFI_NS(7800), .MAX_POSTPONE(MAXP),
                   .XSNR_CYC(XSNR), .XSRD_CYC(XSRD)) i_rfsh_scheduler (
    .clk(clk), .rstN(rstN), .banksIdle(banksIdle), .refAck(refAck),
    .srReq(srReq), .pdReq(pdReq), .refReq(refReq), .grantRead(grantRead),
    .grantOther(grantOther), .cke(cke), .selfRefresh(selfRefresh));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expRefReq(input int st, input int owed, input logic idle);
    return (st == 0) && (owed != 0) && idle;
  endfunction

  function automatic bit expGrantRead(input int st, input int holdR, input int owed);
    return (st == 0) && (holdR == 0) && (owed != MAXP);
  endfunction

  // model step at each rising edge, from the requirements
  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTick = 0; mOwed = 0; mHoldO = 0; mHoldR = 0;
    end else begin
      int nst;
      bit tk, ack;
      ack = expRefReq(mState, mOwed, banksIdle) && refAck;
      tk  = (mState != 1) && (mTick == REFI - 1);
      nst = mState;
      if (mState == 0) begin
        if (srReq && banksIdle) nst = 1;
        else if (pdReq && !srReq && mOwed == 0) nst = 2;
      end else if (mState == 1) begin
        if (!srReq) nst = 0;
      end else begin
        if (!pdReq || srReq || mOwed != 0) nst = 0;
      end
      if (mHoldO > 0) mHoldO--;
      if (mHoldR > 0) mHoldR--;
      if (mState == 1 && nst == 0) begin
        mHoldO = XSNR; mHoldR = XSRD; mTick = 0;
      end else if (mState != 1) begin
        mTick = tk ? 0 : mTick + 1;
      end
      if (mState == 0 && nst == 1) mOwed = 0;
      else if (tk && !ack) begin if (mOwed < MAXP) mOwed++; end
      else if (!tk && ack) mOwed--;
      mState = nst;
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (modelOn && rstN && !done) begin
      check(refReq == expRefReq(mState, mOwed, banksIdle), "R2 refReq", refReq,
            expRefReq(mState, mOwed, banksIdle));
      check(grantOther == ((mState == 0) && (mHoldO == 0)), "R7 grantOther", grantOther,
            (mState == 0) && (mHoldO == 0));
      check(grantRead == expGrantRead(mState, mHoldR, mOwed), "R8 grantRead", grantRead,
            expGrantRead(mState, mHoldR, mOwed));
      check(cke == (mState == 0), "R9 cke", cke, mState == 0);
      check(selfRefresh == (mState == 1), "R5 selfRefresh", selfRefresh, mState == 1);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finishRun();
  end

  initial begin
    int n;
    void'($urandom(32'h0051_7e0d));
    repeat (3) step();
    // R1: reset values
    check(cke && grantRead && grantOther && !refReq && !selfRefresh, "R1 reset",
          {cke, grantRead, grantOther, refReq, selfRefresh}, 5'b11100);
    rstN = 1'b1;
    modelOn = 1;
    check(cke && grantRead && grantOther && !refReq && !selfRefresh, "R1 after release",
          {cke, grantRead, grantOther, refReq, selfRefresh}, 5'b11100);

    // R2: first refresh owed after REFI edges
    n = 0;
    while (!refReq && n < REFI + 10) begin step(); n++; end
    check(n == REFI, "R2 first interval", n, REFI);

    // R3: ack without request ignored, ack with request retires one
    banksIdle = 1'b0; step();
    refAck = 1'b1; step(); refAck = 1'b0;
    banksIdle = 1'b1; step();
    check(refReq == 1'b1, "R3 stray ack ignored", refReq, 1);
    refAck = 1'b1; step(); refAck = 1'b0; step();
    check(refReq == 1'b0, "R3 ack retires", refReq, 0);

    // R4: fill the backlog to its bound
    n = 0;
    while (grantRead && n < (MAXP + 1) * REFI) begin step(); n++; end
    check(!grantRead && refReq, "R4 read blocked at bound", grantRead, 0);
    repeat (REFI) step();          // one more expiry, dropped
    refAck = 1'b1;
    n = 0;
    while (refReq && n < 2 * MAXP) begin step(); n++; end
    refAck = 1'b0;
    check(n == MAXP, "R4 acks to drain", n, MAXP);
    check(grantRead == 1'b1, "R4 read released", grantRead, 1);

    // R5: self-refresh needs idle banks
    srReq = 1'b1; banksIdle = 1'b0;
    repeat (3) step();
    check(!selfRefresh && cke, "R5 busy banks no entry", selfRefresh, 0);
    banksIdle = 1'b1; step();
    check(selfRefresh && !cke, "R5 entry", cke, 0);

    // R6: stay, no refresh requests
    n = 0;
    for (int i = 0; i < 3 * REFI; i++) begin step(); if (refReq || !selfRefresh) n++; end
    check(n == 0, "R6 quiet in self-refresh", n, 0);

    // R7/R8: hold-off windows after exit
    srReq = 1'b0; step();
    check(cke == 1'b1, "R7 cke raised", cke, 1);
    n = 0;
    while (!grantOther && n < XSRD + 10) begin n++; step(); end
    check(n == XSNR, "R7 non-read hold-off", n, XSNR);
    n += 0;
    while (!grantRead && n < XSRD + 10) begin n++; step(); end
    check(n == XSRD, "R8 read hold-off", n, XSRD);

    // R9: power-down entry and exit
    pdReq = 1'b1; step();
    check(!cke && !grantOther && !grantRead, "R9 power-down entry", cke, 0);
    pdReq = 1'b0; step();
    check(cke == 1'b1, "R9 power-down exit", cke, 1);
    pdReq = 1'b1;
    n = 0;
    while (!refReq && n < REFI + 10) begin step(); n++; end
    check(cke && refReq, "R9 due refresh ends power-down", {cke, refReq}, 2'b11);
    step();
    check(cke == 1'b1, "R9 no re-entry while owed", cke, 1);
    refAck = 1'b1; step(); refAck = 1'b0; step();
    check(cke == 1'b0, "R9 re-entry after ack", cke, 0);

    // R10: self-refresh wins over power-down
    pdReq = 1'b0; step();
    srReq = 1'b1; pdReq = 1'b1; step();
    check(selfRefresh && !cke, "R10 priority", selfRefresh, 1);
    srReq = 1'b0; pdReq = 1'b0;
    repeat (XSRD + 5) step();

    // random phase, checked by the model every cycle
    for (int i = 0; i < 15000; i++) begin
      banksIdle = ($urandom % 4) != 0;
      refAck    = ($urandom % 3) == 0;
      if ($urandom % 300 == 0) srReq = ~srReq;
      if ($urandom % 150 == 0) pdReq = ~pdReq;
      if ($urandom % 40 == 0) refAck = 1'b0;
      step();
    end
    finishRun();
  end

endmodule